// File: doc/BRIEF.md
# Floppy controller status register file

This block is the byte-wide register file at the front of a PC-style floppy disk controller. A host bus reads and writes it through a 3-bit register offset. Offset 0 returns status A, offset 1 returns status B (both are read-only), and offset 2 is the digital output register. Reads are combinational. A write is a single-cycle strobe.

Status B shows which motors are enabled and which drive is selected, as last written to the output register. Status A carries a flag that shows no second drive is attached. It also carries the interrupt-pending flag, which is the block's only interrupt state.

The command engine sends raise and clear requests to a small sequencer with two states, `IRQ_IDLE` and `IRQ_PEND`. This sequencer drives the interrupt line and holds an 8-bit interrupt status code. The named transitions are:
- RAISE: `IRQ_IDLE` to `IRQ_PEND`.
- RERAISE: `IRQ_PEND` to `IRQ_PEND`, which updates the code only.
- CLEAR: `IRQ_PEND` to `IRQ_IDLE`.
- CTRL_RESET: `IRQ_PEND` to `IRQ_IDLE`, forced by a controller reset.
- HOLD: any state that stays unchanged for lack of a request.

A controller reset happens when the output register is written with its active-low reset bit at 0. It reloads both status registers and samples the drive-present input again.

Top module: `fdc_status_regs`

## Requirements
- R1: Read offset 0 returns status A, offset 1 returns status B and offset 2 returns the output register. Offsets 3 to 7 read 0x00. Reads are combinational on `addr`.
- R2: Status A bit 7 is interrupt pending and bit 6 is "no second drive". Bits 5 to 0 read 0.
- R3: After hardware reset:
  - the output register is 0x00;
  - status B is 0xC0;
  - status A is 0x00 with bit 6 set if `drive1_present` is low;
  - `irq` is 0 and `int_code` is 0x00.
- R4: A write to offset 2 stores the byte, and later reads of offset 2 return it.
- R5: Every write to offset 2 updates status B from the same cycle's written byte: bit 4 goes to status B bit 0, bit 5 goes to bit 1, and bit 0 goes to bit 5. The other status B bits are left as they were.
- R6: A write to offset 2 with bit 2 at 0 is a controller reset. Status B reloads 0xC0 before the R5 copy is applied. The interrupt-pending flag and `irq` clear. Status A bit 6 samples `drive1_present` again. `int_code` is unchanged.
- R7: A raise request while nothing is pending sets `irq` and status A bit 7 on the next cycle, and latches `raise_code` into `int_code`.
- R8: A raise request while an interrupt is pending keeps `irq` high and only replaces `int_code`. Without a raise, `int_code` holds.
- R9: A clear request while pending drops `irq` and status A bit 7 on the next cycle. A clear request while idle has no effect.
- R10: Within one cycle, a controller reset takes priority over a raise, and a raise takes priority over a clear.
- R11: Writes to offsets 0, 1 and 3 to 7 are ignored and change no register.
- R12: `irq` always equals status A bit 7.
- R13: `drive1_present` is sampled only at hardware or controller reset. Changes at other times leave status A unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Combinational read byte |
| raise_req | input | 1 | Raise-interrupt request from the command engine |
| raise_code | input | 8 | Interrupt status code carried with a raise |
| clear_req | input | 1 | Clear-interrupt request |
| drive1_present | input | 1 | High when a second drive is attached |
| irq | output | 1 | Interrupt line |
| int_code | output | 8 | Latched interrupt status code |

## Verification
The hardest case to reach is a controller reset that lands in the same cycle as a raise and a clear. It must land while an interrupt is already pending, and after `drive1_present` has changed without any reset. Only that combination shows both the priority order and the resampling of the drive-present flag.

The stimulus builds up a pending interrupt and toggles `drive1_present`. It reads status A to show that nothing moved. It then fires an output-register write with bit 2 clear together with both requests.

A long stretch of random bus and request traffic follows. A behavioural model checks it against every read offset on every cycle.

// File: rtl/fdc_sr_pkg.sv
package fdc_sr_pkg;

    localparam int REG_W = 8;

    // register offsets decoded by the read and write paths
    localparam int OFS_STAT_A = 0;
    localparam int OFS_STAT_B = 1;
    localparam int OFS_DOR    = 2;

    // status A bit positions
    localparam int SA_NODRV2  = 6;
    localparam int SA_PEND    = 7;

    // status B bit positions
    localparam int SB_MOT0    = 0;
    localparam int SB_MOT1    = 1;
    localparam int SB_DSEL    = 5;
    localparam logic [REG_W-1:0] SB_RESET = 8'hC0;

    // output register bit positions
    localparam int DOR_DSEL   = 0;
    localparam int DOR_NRST   = 2;
    localparam int DOR_MOT0   = 4;
    localparam int DOR_MOT1   = 5;

    typedef enum logic [1:0] {
        IRQ_IDLE = 2'b01,
        IRQ_PEND = 2'b10
    } irq_state_t;

    typedef struct packed {
        logic set;
        logic clr;
    } pend_cmd_t;

endpackage

// File: rtl/fdc_sr_dor.sv
module fdc_sr_dor
    import fdc_sr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] dor_q,
    output logic             ctrl_rst
);

    // a write with the active-low reset bit at zero resets the controller
    assign ctrl_rst = wr_stb & ~wr_data[DOR_NRST];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dor_q <= '0;
        end else if (wr_stb) begin
            dor_q <= wr_data;
        end
    end

endmodule

// File: rtl/fdc_sr_irq_fsm.sv
module fdc_sr_irq_fsm
    import fdc_sr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_rst,
    input  logic             raise_req,
    input  logic [REG_W-1:0] raise_code,
    input  logic             clear_req,
    output pend_cmd_t        pend_cmd,
    output logic             irq,
    output logic [REG_W-1:0] int_code
);

    irq_state_t state_q, state_d;
    logic       take_raise;

    assign take_raise = raise_req & ~ctrl_rst;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: RAISE, RERAISE, CLEAR, CTRL_RESET, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (take_raise) begin
                    state_d = IRQ_PEND;
                end
            end
            IRQ_PEND: begin
                if (ctrl_rst) begin
                    state_d = IRQ_IDLE;
                end else if (raise_req) begin
                    state_d = IRQ_PEND;
                end else if (clear_req) begin
                    state_d = IRQ_IDLE;
                end
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    // outputs: commands to status A, the interrupt line and the code
    always_comb begin
        pend_cmd.set = (state_q == IRQ_IDLE) && (state_d == IRQ_PEND);
        pend_cmd.clr = (state_q == IRQ_PEND) && (state_d == IRQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            int_code <= '0;
        end else begin
            irq <= (state_d == IRQ_PEND);
            if (take_raise) begin
                int_code <= raise_code;
            end
        end
    end

endmodule

// File: rtl/fdc_sr_status.sv
module fdc_sr_status
    import fdc_sr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_rst,
    input  logic             drive1_present,
    input  pend_cmd_t        pend_cmd,
    input  logic             dor_wr,
    input  logic [REG_W-1:0] dor_data,
    output logic [REG_W-1:0] sra,
    output logic [REG_W-1:0] srb
);

    logic [REG_W-1:0] srb_base;

    always_comb begin
        srb_base = ctrl_rst ? SB_RESET : srb;
        if (dor_wr) begin
            srb_base[SB_MOT0] = dor_data[DOR_MOT0];
            srb_base[SB_MOT1] = dor_data[DOR_MOT1];
            srb_base[SB_DSEL] = dor_data[DOR_DSEL];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srb <= SB_RESET;
        end else begin
            srb <= srb_base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sra            <= '0;
            sra[SA_NODRV2] <= ~drive1_present;
        end else if (ctrl_rst) begin
            sra            <= '0;
            sra[SA_NODRV2] <= ~drive1_present;
        end else if (pend_cmd.set) begin
            sra[SA_PEND]   <= 1'b1;
        end else if (pend_cmd.clr) begin
            sra[SA_PEND]   <= 1'b0;
        end
    end

endmodule

// File: rtl/fdc_status_regs.sv
module fdc_status_regs
    import fdc_sr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              raise_req,
    input  logic [REG_W-1:0]  raise_code,
    input  logic              clear_req,
    input  logic              drive1_present,
    output logic              irq,
    output logic [REG_W-1:0]  int_code
);

    localparam logic [ADDR_W-1:0] A_SRA = ADDR_W'(OFS_STAT_A);
    localparam logic [ADDR_W-1:0] A_SRB = ADDR_W'(OFS_STAT_B);
    localparam logic [ADDR_W-1:0] A_DOR = ADDR_W'(OFS_DOR);

    logic             dor_wr;
    logic             ctrl_rst;
    logic [REG_W-1:0] dor_q;
    logic [REG_W-1:0] sra_q;
    logic [REG_W-1:0] srb_q;
    pend_cmd_t        pend_cmd;

    assign dor_wr = wr_en && (addr == A_DOR);

    fdc_sr_dor u_dor (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (dor_wr),
        .wr_data  (wr_data),
        .dor_q    (dor_q),
        .ctrl_rst (ctrl_rst)
    );

    fdc_sr_irq_fsm u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_rst   (ctrl_rst),
        .raise_req  (raise_req),
        .raise_code (raise_code),
        .clear_req  (clear_req),
        .pend_cmd   (pend_cmd),
        .irq        (irq),
        .int_code   (int_code)
    );

    fdc_sr_status u_stat (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctrl_rst       (ctrl_rst),
        .drive1_present (drive1_present),
        .pend_cmd       (pend_cmd),
        .dor_wr         (dor_wr),
        .dor_data       (wr_data),
        .sra            (sra_q),
        .srb            (srb_q)
    );

    always_comb begin
        unique case (addr)
            A_SRA:   rd_data = sra_q;
            A_SRB:   rd_data = srb_q;
            A_DOR:   rd_data = dor_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/fdc_sr_checker.sv
module fdc_sr_checker #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [7:0]        rd_data,
    input logic              raise_req,
    input logic [7:0]        raise_code,
    input logic              clear_req,
    input logic              irq,
    input logic [7:0]        int_code,
    input logic [7:0]        srb
);

    logic dor_wr, crst;
    assign dor_wr = wr_en && (addr == ADDR_W'(2));
    assign crst   = dor_wr && !wr_data[2];

    AST_IRQ_EQ_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(0)) |-> (rd_data[7] == irq)); // R12

    AST_SRA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(0)) |-> (rd_data[5:0] == 6'd0)); // R2

    AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_req && !crst) |=> (irq && int_code == $past(raise_code))); // R7

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !raise_req) |=> !irq); // R9

    AST_CRST_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        crst |=> (!irq && $stable(int_code))); // R6

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !raise_req |=> $stable(int_code)); // R8

    AST_SRB_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        dor_wr |=> (srb[0] == $past(wr_data[4]) && srb[1] == $past(wr_data[5])
                    && srb[5] == $past(wr_data[0]))); // R5

    AST_CRST_SRB: assert property (@(posedge clk) disable iff (!rst_n)
        crst |=> (srb[7:6] == 2'b11 && srb[4:2] == 3'd0)); // R6

    AST_RO_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dor_wr) |=> $stable(srb)); // R11

endmodule

bind fdc_status_regs fdc_sr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .raise_req  (raise_req),
    .raise_code (raise_code),
    .clear_req  (clear_req),
    .irq        (irq),
    .int_code   (int_code),
    .srb        (srb_q)
);

// File: tb/sim_fdc_status_regs.sv
`timescale 1ns/1ps
module sim_fdc_status_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       raise_req = 1'b0;
    logic [7:0] raise_code = '0;
    logic       clear_req = 1'b0;
    logic       drive1_present = 1'b0;
    logic       irq;
    logic [7:0] int_code;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;
    string cur = "R3";

    always #2.5 clk = ~clk;

    fdc_status_regs u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .raise_req(raise_req), .raise_code(raise_code),
        .clear_req(clear_req), .drive1_present(drive1_present),
        .irq(irq), .int_code(int_code)
    );

    // behavioural reference model
    logic [7:0] m_dor, m_srb, m_code;
    logic       m_pend, m_nodrv2;

    always @(posedge clk) begin
        logic [7:0] t;
        logic       dw, cr;
        if (!rst_n) begin
            m_dor    <= 8'h00;
            m_srb    <= 8'hC0;
            m_code   <= 8'h00;
            m_pend   <= 1'b0;
            m_nodrv2 <= !drive1_present;
        end else begin
            dw = wr_en && (addr == 3'd2);
            cr = dw && !wr_data[2];
            t  = cr ? 8'hC0 : m_srb;
            if (dw) begin
                m_dor <= wr_data;
                t[0] = wr_data[4];
                t[1] = wr_data[5];
                t[5] = wr_data[0];
            end
            m_srb <= t;
            if (cr) begin
                m_pend   <= 1'b0;
                m_nodrv2 <= !drive1_present;
            end else if (raise_req) begin
                m_pend <= 1'b1;
                m_code <= raise_code;
            end else if (clear_req) begin
                m_pend <= 1'b0;
            end
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0:    return {m_pend, m_nodrv2, 6'd0};
            3'd1:    return m_srb;
            3'd2:    return m_dor;
            default: return 8'h00;
        endcase
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            n_chk++;
            if (rd_data !== exp_rd(addr)) begin
                n_fail++;
                $display("FAIL %s rd_data addr=%0d actual=%02h expected=%02h",
                         cur, addr, rd_data, exp_rd(addr));
            end
            n_chk++;
            if (irq !== m_pend) begin
                n_fail++;
                $display("FAIL %s irq actual=%0b expected=%0b", cur, irq, m_pend);
            end
            n_chk++;
            if (int_code !== m_code) begin
                n_fail++;
                $display("FAIL %s int_code actual=%02h expected=%02h", cur, int_code, m_code);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic rd(input logic [2:0] a);
        addr = a;
        step();
    endtask

    task automatic rd_all();
        for (int i = 0; i < 8; i++) rd(3'(i));
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic raise(input logic [7:0] c);
        raise_req = 1'b1; raise_code = c;
        step();
        raise_req = 1'b0;
    endtask

    task automatic clear();
        clear_req = 1'b1;
        step();
        clear_req = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R3: reset state with no second drive
        repeat (3) step();
        rst_n = 1'b1;
        chk_en = 1'b1;
        cur = "R3"; rd_all();
        // R1 / R4: output register store and decode
        cur = "R4"; wr(3'd2, 8'h0C); rd(3'd2);
        cur = "R1"; rd_all();
        // R5: mirror bits into status B
        cur = "R5"; wr(3'd2, 8'h3D); rd(3'd1); wr(3'd2, 8'h1C); rd(3'd1);
        wr(3'd2, 8'h2D); rd(3'd1);
        // R11: writes to read-only and unused offsets ignored
        cur = "R11";
        wr(3'd0, 8'hFF); rd(3'd0); wr(3'd1, 8'h00); rd(3'd1);
        for (int i = 3; i < 8; i++) begin wr(3'(i), 8'hA5); rd_all(); end
        // R7: raise while idle
        cur = "R7"; addr = 3'd0; raise(8'h20); rd(3'd0);
        // R8: raise while pending replaces the code
        cur = "R8"; raise(8'h41); rd(3'd0); rd(3'd1);
        // R9: clear while pending, then clear while idle
        cur = "R9"; clear(); rd(3'd0); clear(); rd(3'd0);
        // R10: raise and clear in the same cycle, raise wins
        cur = "R10"; raise_req = 1'b1; raise_code = 8'h77; clear_req = 1'b1; step();
        raise_req = 1'b0; clear_req = 1'b0; rd(3'd0);
        // R13: drive presence change without a reset leaves status A
        cur = "R13"; drive1_present = 1'b1; rd(3'd0); rd(3'd0);
        // R6 + R10: controller reset together with raise and clear while pending
        cur = "R6";
        raise_req = 1'b1; raise_code = 8'h99; clear_req = 1'b1;
        addr = 3'd2; wr_data = 8'h31; wr_en = 1'b1;
        step();
        raise_req = 1'b0; clear_req = 1'b0; wr_en = 1'b0;
        rd_all();
        wr(3'd2, 8'h04); rd(3'd1);
        // R3: hardware reset with a second drive attached, then R2 layout
        cur = "R3"; rst_n = 1'b0; step(); step(); rst_n = 1'b1; rd_all();
        cur = "R2"; raise(8'h01); rd(3'd0);
        // R12 / R10: random traffic against the model
        cur = "R12";
        for (int i = 0; i < 3000; i++) begin
            addr = 3'($urandom);
            wr_en = ($urandom % 4) == 0;
            wr_data = 8'($urandom);
            raise_req = ($urandom % 5) == 0;
            raise_code = 8'($urandom);
            clear_req = ($urandom % 4) == 0;
            if (($urandom % 50) == 0) drive1_present = ~drive1_present;
            step();
        end
        wr_en = 1'b0; raise_req = 1'b0; clear_req = 1'b0;
        rd_all();
        summary();
    end

endmodule